// File: doc/BRIEF.md
# Virtual Wire State Bank

This block stores the sideband virtual wires of a serial peripheral link as byte-wide groups. Each group is named by an index. A host register port sees the groups packed four to a 32-bit word. The word offset is the index divided by four, and the byte lane inside the word is the index modulo four. A link-side port reads and updates one group at a time by index; it serves the packet engine that turns groups into bus traffic.

Some system groups are also decoded onto discrete pins. These are the interrupt group, the three active-low sleep wires and the slave-boot-done flag. Other logic can therefore use them without polling the register port. All writes take effect at the clock edge that samples them. Both read ports are combinational on the current state.

Top module: `vw_state_bank`

## Requirements
- R1: After reset, group 0x02 holds 0x07 (all three sleep wires deasserted) and every other group holds 0x00.
- R2: `host_rdata` returns the word at `host_addr`. Group `4*host_addr+k` sits in bits `8*k+7:8*k`.
- R3: A host write updates only the byte lanes whose `host_be` bit is 1. The other lanes of that word keep their values.
- R4: A link write stores `link_wdata` into group `link_idx`. `link_rdata` returns the group selected by `link_idx`.
- R5: When a host write and a link write hit the same group in one cycle, the group takes the link data. When they hit different groups, both updates land.
- R6: 64 groups (16 words) exist. A host word offset of 16 or more reads as zero and its write changes nothing. A link index of 64 or more reads as zero and its write changes nothing.
- R7: `irq_lines` mirrors group 0x00 bit for bit.
- R8: `sleep3_n`, `sleep4_n` and `sleep5_n` are bits 0, 1 and 2 of group 0x02. A value of 0 means the sleep state is asserted.
- R9: `boot_ready` is bit 0 of group 0x04 and is 1 once the slave has reported that its boot load is done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host word write strobe |
| host_addr | input | 6 | Host word offset |
| host_be | input | 4 | Host byte-lane enables |
| host_wdata | input | 32 | Host write word |
| host_rdata | output | 32 | Word at host_addr |
| link_we | input | 1 | Link group write strobe |
| link_idx | input | 8 | Link group index |
| link_wdata | input | 8 | Link group write data |
| link_rdata | output | 8 | Group at link_idx |
| irq_lines | output | 8 | Interrupt group |
| sleep3_n | output | 1 | Active-low light-sleep wire |
| sleep4_n | output | 1 | Active-low hibernate wire |
| sleep5_n | output | 1 | Active-low soft-off wire |
| boot_ready | output | 1 | Slave boot-load-done flag |

## Verification
The bench uses the default parameters: 64 groups, a 6-bit host word offset and an 8-bit link index. With these widths, word offsets 16 to 63 and indices 64 to 255 can be reached. Random traffic therefore lands often outside the bank, so writes that must be ignored and reads that must return zero are exercised alongside in-range traffic. Random host and link writes are also often made in the same cycle. This covers collisions on the same group and on neighbouring lanes of one word.

// File: rtl/vw_pkg.sv
package vw_pkg;
    typedef logic [7:0] vw_byte_t;

    localparam int VW_IRQ_IDX   = 0;
    localparam int VW_SLEEP_IDX = 2;
    localparam int VW_BOOT_IDX  = 4;
    localparam int VW_BOOT_BIT  = 0;

    // reset value of a group: sleep wires deasserted (high), all else low
    function automatic vw_byte_t vw_reset_byte(input int idx);
        return (idx == VW_SLEEP_IDX) ? 8'h07 : 8'h00;
    endfunction
endpackage

// File: rtl/vw_hit_decode.sv
module vw_hit_decode #(
    parameter int NUM_GROUPS = 64,
    parameter int HADDR_W    = 6,
    parameter int LIDX_W     = 8
) (
    input  logic                  host_we,
    input  logic [HADDR_W-1:0]    host_addr,
    input  logic [3:0]            host_be,
    input  logic                  link_we,
    input  logic [LIDX_W-1:0]     link_idx,
    output logic [NUM_GROUPS-1:0] host_hit,
    output logic [NUM_GROUPS-1:0] link_hit
);
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_hit
        localparam int WORD = g / 4;
        localparam int LANE = g % 4;
        assign host_hit[g] = host_we && (host_addr == HADDR_W'(WORD)) && host_be[LANE];
        assign link_hit[g] = link_we && (link_idx == LIDX_W'(g));
    end
endmodule

// File: rtl/vw_read_mux.sv
module vw_read_mux #(
    parameter int NUM_GROUPS = 64,
    parameter int HADDR_W    = 6,
    parameter int LIDX_W     = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_GROUPS-1:0][7:0]    grp,
    input  logic [HADDR_W-1:0]            host_addr,
    input  logic [LIDX_W-1:0]             link_idx,
    output logic [31:0]                   host_rdata,
    output logic [7:0]                    link_rdata
);
    localparam int NUM_WORDS = NUM_GROUPS / 4;

    always_comb begin
        host_rdata = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (host_addr == HADDR_W'(w)) begin
                host_rdata = {grp[4*w+3], grp[4*w+2], grp[4*w+1], grp[4*w]};
            end
        end
    end

    always_comb begin
        link_rdata = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (link_idx == LIDX_W'(g)) begin
                link_rdata = grp[g];
            end
        end
    end

    // R6: offsets beyond the bank read as zero on both ports
    a_r6_host_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(host_addr) >= NUM_WORDS) |-> (host_rdata == 32'h0));
    a_r6_link_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(link_idx) >= NUM_GROUPS) |-> (link_rdata == 8'h0));
endmodule

// File: rtl/vw_sys_decode.sv
module vw_sys_decode (
    input  logic [7:0] irq_grp,
    input  logic [2:0] sleep_bits,
    input  logic       boot_bit,
    output logic [7:0] irq_lines,
    output logic       sleep3_n,
    output logic       sleep4_n,
    output logic       sleep5_n,
    output logic       boot_ready
);
    always_comb begin
        irq_lines  = irq_grp;
        sleep3_n   = sleep_bits[0];
        sleep4_n   = sleep_bits[1];
        sleep5_n   = sleep_bits[2];
        boot_ready = boot_bit;
    end
endmodule

// File: rtl/vw_state_bank.sv
module vw_state_bank #(
    parameter int NUM_GROUPS = 64,
    parameter int HADDR_W    = 6,
    parameter int LIDX_W     = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_we,
    input  logic [HADDR_W-1:0] host_addr,
    input  logic [3:0]         host_be,
    input  logic [31:0]        host_wdata,
    output logic [31:0]        host_rdata,
    input  logic               link_we,
    input  logic [LIDX_W-1:0]  link_idx,
    input  logic [7:0]         link_wdata,
    output logic [7:0]         link_rdata,
    output logic [7:0]         irq_lines,
    output logic               sleep3_n,
    output logic               sleep4_n,
    output logic               sleep5_n,
    output logic               boot_ready
);
    import vw_pkg::*;

    typedef struct packed {
        logic [NUM_GROUPS-1:0][7:0] grp;
    } bank_t;

    bank_t st_d, st_q;
    logic [NUM_GROUPS-1:0] host_hit, link_hit;

    vw_hit_decode #(.NUM_GROUPS(NUM_GROUPS), .HADDR_W(HADDR_W), .LIDX_W(LIDX_W)) i_hit (
        .host_we  (host_we),
        .host_addr(host_addr),
        .host_be  (host_be),
        .link_we  (link_we),
        .link_idx (link_idx),
        .host_hit (host_hit),
        .link_hit (link_hit)
    );

    always_comb begin
        st_d = st_q;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (link_hit[g]) begin
                st_d.grp[g] = link_wdata;               // link side has priority
            end else if (host_hit[g]) begin
                st_d.grp[g] = host_wdata[8*(g%4) +: 8];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int g = 0; g < NUM_GROUPS; g++) begin
                st_q.grp[g] <= vw_reset_byte(g);
            end
        end else begin
            st_q <= st_d;
        end
    end

    vw_read_mux #(.NUM_GROUPS(NUM_GROUPS), .HADDR_W(HADDR_W), .LIDX_W(LIDX_W)) i_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .grp       (st_q.grp),
        .host_addr (host_addr),
        .link_idx  (link_idx),
        .host_rdata(host_rdata),
        .link_rdata(link_rdata)
    );

    vw_sys_decode i_sys (
        .irq_grp   (st_q.grp[VW_IRQ_IDX]),
        .sleep_bits(st_q.grp[VW_SLEEP_IDX][2:0]),
        .boot_bit  (st_q.grp[VW_BOOT_IDX][VW_BOOT_BIT]),
        .irq_lines (irq_lines),
        .sleep3_n  (sleep3_n),
        .sleep4_n  (sleep4_n),
        .sleep5_n  (sleep5_n),
        .boot_ready(boot_ready)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
        localparam int WORD = g / 4;
        localparam int LANE = g % 4;
        // R5: a link write always lands, host collision or not
        a_r5_link_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (link_we && link_idx == LIDX_W'(g)) |=> (st_q.grp[g] == $past(link_wdata)));
        // R3: a host write to the word leaves disabled lanes alone
        a_r3_lane_keep: assert property (@(posedge clk) disable iff (!rst_n)
            (host_we && host_addr == HADDR_W'(WORD) && !host_be[LANE] &&
             !(link_we && link_idx == LIDX_W'(g))) |=> $stable(st_q.grp[g]));
        // R6: a group no port addresses keeps its value
        a_r6_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
            (!(host_we && host_addr == HADDR_W'(WORD)) &&
             !(link_we && link_idx == LIDX_W'(g))) |=> $stable(st_q.grp[g]));
    end
endmodule

// File: tb/test_vw_state_bank.sv
module test_vw_state_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [5:0]  host_addr = '0;
    logic [3:0]  host_be = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        link_we = 1'b0;
    logic [7:0]  link_idx = '0;
    logic [7:0]  link_wdata = '0;
    logic [7:0]  link_rdata;
    logic [7:0]  irq_lines;
    logic        sleep3_n, sleep4_n, sleep5_n, boot_ready;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] model [64];

    always #2 clk = ~clk;   // 250 MHz

    vw_state_bank i_vw_state_bank (
        .clk(clk), .rst_n(rst_n),
        .host_we(host_we), .host_addr(host_addr), .host_be(host_be),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .link_we(link_we), .link_idx(link_idx), .link_wdata(link_wdata),
        .link_rdata(link_rdata), .irq_lines(irq_lines),
        .sleep3_n(sleep3_n), .sleep4_n(sleep4_n), .sleep5_n(sleep5_n),
        .boot_ready(boot_ready)
    );

    function automatic logic [31:0] exp_word(input int w);
        if (w >= 16) return 32'h0;
        return {model[4*w+3], model[4*w+2], model[4*w+1], model[4*w]};
    endfunction

    function automatic logic [7:0] exp_grp(input int i);
        return (i >= 64) ? 8'h00 : model[i];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one write cycle; model follows R3, R5, R6
    task automatic do_write(input logic hwe, input int ha, input logic [3:0] be,
                            input logic [31:0] hwd, input logic lwe, input int li,
                            input logic [7:0] lwd);
        @(negedge clk);
        host_we = hwe; host_addr = 6'(ha); host_be = be; host_wdata = hwd;
        link_we = lwe; link_idx = 8'(li); link_wdata = lwd;
        @(posedge clk);
        if (hwe && ha < 16)
            for (int k = 0; k < 4; k++)
                if (be[k] && !(lwe && li == 4*ha + k)) model[4*ha+k] = hwd[8*k +: 8];
        if (lwe && li < 64) model[li] = lwd;
        @(negedge clk);
        host_we = 1'b0; link_we = 1'b0;
    endtask

    task automatic check_word(input string req, input int w);
        host_addr = 6'(w);
        #1;
        check(req, host_rdata, exp_word(w));
    endtask

    task automatic check_grp(input string req, input int i);
        link_idx = 8'(i);
        #1;
        check(req, {24'h0, link_rdata}, {24'h0, exp_grp(i)});
    endtask

    task automatic check_pins();
        check("R7 irq_lines", {24'h0, irq_lines}, {24'h0, model[0]});
        check("R8 sleep wires", {29'h0, sleep5_n, sleep4_n, sleep3_n}, {29'h0, model[2][2:0]});
        check("R9 boot_ready", {31'h0, boot_ready}, {31'h0, model[4][0]});
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 64; i++) model[i] = (i == 2) ? 8'h07 : 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state, R2 word packing
        for (int w = 0; w < 16; w++) check_word("R1 reset word", w);
        check_pins();

        // R2/R7: full word at offset 0
        do_write(1, 0, 4'hF, 32'hA1B2C3D4, 0, 0, 8'h0);
        check_word("R2 word0 packing", 0);
        check_grp("R2 lane3 is idx3", 3);
        check_pins();

        // R3: partial lanes 0 and 2 on word 3
        do_write(1, 3, 4'hF, 32'h11223344, 0, 0, 8'h0);
        do_write(1, 3, 4'b0101, 32'hEEFFAA55, 0, 0, 8'h0);
        check_word("R3 partial lanes", 3);
        check_grp("R3 kept idx13", 13);

        // R4/R8: link asserts sleep3 (bit0 = 0)
        do_write(0, 0, 4'h0, 32'h0, 1, 2, 8'h06);
        check_grp("R4 link readback", 2);
        check("R8 sleep3 asserted", {31'h0, sleep3_n}, 32'h0);
        check_pins();

        // R5: same index collision, link wins, neighbour lanes still written
        do_write(1, 1, 4'hF, 32'h99887766, 1, 5, 8'h3C);
        check_word("R5 same-index collision", 1);
        // R5: different indices both land
        do_write(1, 2, 4'h1, 32'h000000AB, 1, 9, 8'h5A);
        check_grp("R5 host side lands", 8);
        check_grp("R5 link side lands", 9);

        // R9: boot done
        do_write(0, 0, 4'h0, 32'h0, 1, 4, 8'h01);
        check("R9 boot set", {31'h0, boot_ready}, 32'h1);

        // R6: out-of-range accesses
        do_write(1, 20, 4'hF, 32'hDEADBEEF, 1, 100, 8'hFF);
        for (int w = 0; w < 16; w++) check_word("R6 oob write ignored", w);
        check_word("R6 host oob read", 20);
        check_grp("R6 link oob read", 100);
        check_grp("R6 link idx 64", 64);

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            logic hwe, lwe;
            int ha, li;
            hwe = 1'($urandom);
            lwe = 1'($urandom);
            ha  = $urandom % 20;
            li  = (($urandom % 4) == 0) ? 4*ha + ($urandom % 4) : $urandom % 72;
            do_write(hwe, ha, 4'($urandom), $urandom, lwe, li, 8'($urandom));
            check_word("R2 R3 R5 R6 random word", $urandom % 20);
            check_grp("R4 random group", $urandom % 72);
            check_pins();
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule